// File: doc/BRIEF.md
# Per-Channel Auto-Mute Detector

This block watches a stereo stream of signed PCM samples, one left/right pair per frame strobe. For each channel it decides on its own when that channel has carried a static signal long enough to be muted. A static signal is a run of samples that all hold exactly zero or all hold exactly minus one (every bit set). When a channel's run reaches the threshold, the block raises that channel's mute request. A level-transition controller placed after this block decides how the mute is applied.

A single sample with any other value clears the channel's mute request at once and restarts its count. A mute-indicator pin shows whether either channel is muted, and a parameter sets its polarity. When the enable input is low, both channels are held clear. The block raises no request until the enable is high again and a full run of static samples has been seen.

Top module: `amute_top`

## Requirements
- R1: While reset is high, and on the first cycle after it falls, both mute requests are 0 and the indicator pin is at its inactive level.
- R2: A sample counts as static when it is all zeros (0) or all ones (-1). When a channel accepts its MUTE_COUNT-th consecutive identical static sample (default 8192), its mute request goes to 1 in the cycle that follows that clock edge. After MUTE_COUNT-1 such samples the request is still 0.
- R3: A non-static sample accepted on a channel clears that channel's mute request on the next cycle and restarts its count from zero.
- R4: A change of the static value between 0 and -1 restarts the count, and the new sample counts as the first sample of the new run.
- R5: The left and right channels are counted and muted independently. A sample on one channel never changes the other channel's request.
- R6: The indicator pin is active while at least one mute request is 1. IND_ACTIVE_HIGH=0 (the default) makes the pin low when active. IND_ACTIVE_HIGH=1 makes it high when active.
- R7: While the enable is 0, both mute requests are 0 from the next cycle on and both counts are cleared. After the enable returns to 1, a full run of MUTE_COUNT static samples is needed to mute again.
- R8: On cycles where the frame-valid strobe is 0, the sample inputs are ignored and neither the requests nor the counts change.
- R9: The count saturates at MUTE_COUNT. However long a static run continues, the channel stays muted and the count never wraps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| amute_en | input | 1 | Auto-mute enable |
| frame_vld | input | 1 | Strobe marking a valid left/right sample pair |
| smp_l | input | SAMPLE_W | Left sample, two's complement |
| smp_r | input | SAMPLE_W | Right sample, two's complement |
| mute_req_l | output | 1 | Left-channel mute request |
| mute_req_r | output | 1 | Right-channel mute request |
| mute_pin | output | 1 | Mute indicator, polarity set by IND_ACTIVE_HIGH |

## Verification
Every result is registered once. A sample accepted at a rising edge therefore shows its effect on the requests and the indicator in the cycle after that edge. This holds for a release, a change of static value, or the enable falling. The bench drives inputs on the falling edge. A behavioural model updates its integer counters at the rising edge from the same inputs. The design's outputs are compared with the model on every falling edge, half a cycle after the rising edge that updated both. The stimulus reaches the exact edges that matter: the MUTE_COUNT-1 and MUTE_COUNT sample boundary, a single non-static sample, a flip between 0 and -1, strobe-low gaps, and an enable drop in the middle of a mute.

// File: rtl/amute_pkg.sv
package amute_pkg;

    // Class of one incoming sample
    typedef enum logic [1:0] {
        LVL_NONE = 2'd0,
        LVL_ZERO = 2'd1,
        LVL_ONES = 2'd2
    } lvl_e;

    // Registered per-channel tracking state, apart from the counter
    typedef struct packed {
        lvl_e run_lvl;
        logic muted;
    } chan_state_t;

    localparam chan_state_t CHAN_IDLE = '{run_lvl: LVL_NONE, muted: 1'b0};

endpackage

// File: rtl/amute_classify.sv
module amute_classify
    import amute_pkg::*;
#(
    parameter int SAMPLE_W = 16
) (
    input  logic [SAMPLE_W-1:0] sample,
    output lvl_e                lvl
);
    always_comb begin
        if (sample == '0)
            lvl = LVL_ZERO;
        else if (sample == '1)
            lvl = LVL_ONES;
        else
            lvl = LVL_NONE;
    end
endmodule

// File: rtl/amute_channel.sv
module amute_channel
    import amute_pkg::*;
#(
    parameter int SAMPLE_W   = 16,
    parameter int MUTE_COUNT = 8192
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    input  logic                vld,
    input  logic [SAMPLE_W-1:0] sample,
    output logic                mute
);
    localparam int CNT_W = $clog2(MUTE_COUNT + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MUTE_COUNT);

    lvl_e             lvl_in;
    chan_state_t      st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    amute_classify #(.SAMPLE_W(SAMPLE_W)) i_cls (
        .sample (sample),
        .lvl    (lvl_in)
    );

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (!en) begin
            st_d  = CHAN_IDLE;
            cnt_d = '0;
        end else if (vld) begin
            if (lvl_in == LVL_NONE) begin
                st_d  = CHAN_IDLE;
                cnt_d = '0;
            end else begin
                if (lvl_in != st_q.run_lvl)
                    cnt_d = CNT_W'(1);
                else if (cnt_q != CNT_MAX)
                    cnt_d = cnt_q + CNT_W'(1);
                st_d.run_lvl = lvl_in;
                st_d.muted   = (cnt_d == CNT_MAX);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= CHAN_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    assign mute = st_q.muted;

    // R2
    mute_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mute) |-> $past(en && vld && lvl_in != LVL_NONE));

    // R3
    release_chk: assert property (@(posedge clk) disable iff (rst)
        (en && vld && lvl_in == LVL_NONE) |=> !mute);

    // R7
    disable_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!mute && cnt_q == '0));

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (en && !vld) |=> ($stable(mute) && $stable(cnt_q)));

    // R9
    no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_MAX);
endmodule

// File: rtl/amute_top.sv
module amute_top
    import amute_pkg::*;
#(
    parameter int SAMPLE_W        = 16,
    parameter int MUTE_COUNT      = 8192,
    parameter bit IND_ACTIVE_HIGH = 1'b0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                amute_en,
    input  logic                frame_vld,
    input  logic [SAMPLE_W-1:0] smp_l,
    input  logic [SAMPLE_W-1:0] smp_r,
    output logic                mute_req_l,
    output logic                mute_req_r,
    output logic                mute_pin
);
    localparam int NCH = 2;

    logic [SAMPLE_W-1:0] smp   [NCH];
    logic [NCH-1:0]      mutes;

    assign smp[0] = smp_l;
    assign smp[1] = smp_r;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        amute_channel #(
            .SAMPLE_W   (SAMPLE_W),
            .MUTE_COUNT (MUTE_COUNT)
        ) i_ch (
            .clk    (clk),
            .rst    (rst),
            .en     (amute_en),
            .vld    (frame_vld),
            .sample (smp[c]),
            .mute   (mutes[c])
        );
    end

    assign mute_req_l = mutes[0];
    assign mute_req_r = mutes[1];
    assign mute_pin   = IND_ACTIVE_HIGH ? (|mutes) : ~(|mutes);

    // R6
    pin_level_chk: assert property (@(posedge clk) disable iff (rst)
        (mute_pin == IND_ACTIVE_HIGH) == (mute_req_l || mute_req_r));

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!mute_req_l && !mute_req_r));
endmodule

// File: tb/test_amute_top.sv
`timescale 1ns/1ps
module test_amute_top;
    localparam int W  = 16;
    localparam int MC = 8192;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         en  = 1'b1;
    logic         vld = 1'b0;
    logic [W-1:0] sl  = '0;
    logic [W-1:0] sr  = '0;
    logic         ml, mr, pin;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;
    string phase = "R1 reset";

    amute_top #(.SAMPLE_W(W), .MUTE_COUNT(MC), .IND_ACTIVE_HIGH(1'b0)) i_amute_top (
        .clk(clk), .rst(rst), .amute_en(en), .frame_vld(vld),
        .smp_l(sl), .smp_r(sr),
        .mute_req_l(ml), .mute_req_r(mr), .mute_pin(pin)
    );

    always #2 clk = ~clk;

    // Behavioural model: kind 0 = none, 1 = zero, 2 = minus one
    int cnt[2];
    int kind[2];
    bit mq[2];

    function automatic int kind_of(logic [W-1:0] s);
        if (s == '0) return 1;
        if (s == '1) return 2;
        return 0;
    endfunction

    always @(posedge clk) begin
        logic [W-1:0] s[2];
        s[0] = sl; s[1] = sr;
        for (int c = 0; c < 2; c++) begin
            if (rst || !en) begin
                cnt[c] = 0; kind[c] = 0; mq[c] = 0;
            end else if (vld) begin
                int k;
                k = kind_of(s[c]);
                if (k == 0) begin
                    cnt[c] = 0; kind[c] = 0; mq[c] = 0;
                end else begin
                    if (k != kind[c]) cnt[c] = 1;
                    else if (cnt[c] < MC) cnt[c]++;
                    kind[c] = k;
                    mq[c] = (cnt[c] >= MC);
                end
            end
        end
    end

    always @(negedge clk) begin
        bit exp_pin;
        cyc++;
        exp_pin = !(mq[0] || mq[1]);
        n_cmp++;
        if (ml !== mq[0] || mr !== mq[1] || pin !== exp_pin) begin
            n_bad++;
            $display("FAIL %s cycle %0d: actual l=%b r=%b pin=%b expected l=%b r=%b pin=%b",
                     phase, cyc, ml, mr, pin, mq[0], mq[1], exp_pin);
        end
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog: actual cycle %0d expected finish", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic drive(int n, logic [W-1:0] l, logic [W-1:0] r, logic v, logic e);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            sl = l; sr = r; vld = v; en = e;
        end
    endtask

    initial begin
        cnt = '{0, 0}; kind = '{0, 0}; mq = '{0, 0};
        drive(3, '0, '0, 1'b1, 1'b1);
        @(negedge clk); rst = 1'b0; vld = 1'b0;
        drive(2, 16'h0005, 16'h0005, 1'b0, 1'b1);
        phase = "R2 zero run to boundary";
        drive(MC - 1, '0, '0, 1'b1, 1'b1);
        drive(1, '0, '0, 1'b1, 1'b1);
        phase = "R9 saturating static run";
        drive(2000, '0, '0, 1'b1, 1'b1);
        phase = "R3 R5 left release only";
        drive(1, 16'h1234, '0, 1'b1, 1'b1);
        drive(3, 16'h7fff, '0, 1'b1, 1'b1);
        phase = "R2 minus-one run";
        drive(MC, '1, '0, 1'b1, 1'b1);
        phase = "R4 flip to zero restarts";
        drive(100, '0, '1, 1'b1, 1'b1);
        drive(MC - 101, '0, '1, 1'b1, 1'b1);
        phase = "R8 strobe low ignored";
        drive(50, 16'h8000, 16'h0001, 1'b0, 1'b1);
        drive(2, '0, '1, 1'b1, 1'b1);
        phase = "R7 enable low clears";
        drive(MC + 10, '0, '0, 1'b1, 1'b1);
        drive(5, '0, '0, 1'b1, 1'b0);
        drive(MC - 1, '0, '0, 1'b1, 1'b1);
        drive(4, '0, '0, 1'b0, 1'b1);
        drive(2, '0, '0, 1'b1, 1'b1);
        phase = "R5 R6 mixed";
        drive(1, 16'h0001, '0, 1'b1, 1'b1);
        drive(MC + 3, '1, 16'hfffe, 1'b1, 1'b1);
        drive(3, 16'h4000, 16'h4000, 1'b1, 1'b1);
        drive(5, 16'h4000, 16'h4000, 1'b0, 1'b1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule